// File: doc/BRIEF.md
# Dynamic Phase Alignment Delay Controller

This controller sits in the parallel (slow) clock domain of a serial receive lane and chooses a 6-bit input delay tap so that the lane samples each bit near the middle of its period. A behavioural delay line outside the block turns the tap into three observations per cycle: an early, a centre and a late sample of the incoming data. When all three agree, the sample point is judged to sit safely inside the data eye.

In automatic mode the block sweeps every tap from 0 to 63. It holds each tap for 16 slow-clock cycles, and the tap counts as stable only when the three samples agreed in all 16. The block remembers the lowest and the highest stable tap, settles on the tap halfway between them and raises `locked`. While locked, it shows the chosen tap on `dbg_tap`. If no tap was stable, it parks the tap at 0 and raises `no_eye`. Automatic training starts only when the lane runs at full rate. In manual mode the same tap register becomes a saturating up/down counter driven by a step strobe and a direction bit. The step controls have no effect while automatic mode is selected.

States: `S_MAN` (manual stepping), `S_IDLE` (automatic, waiting for enable), `S_DWELL` (observing the current tap), `S_NEXT` (judging the tap and advancing), `S_DECIDE` (loading the midpoint or 0), `S_LOCK` (trained) and `S_FAIL` (no eye found).

Transitions:
- Any state goes to `S_MAN` when `auto_mode` is low.
- `S_MAN` goes to `S_IDLE` when `auto_mode` is high.
- `tap_clr` sends the machine to `S_IDLE` in automatic mode and to `S_MAN` in manual mode.
- `S_IDLE` goes to `S_DWELL` on `step_en` with `full_rate` high.
- `S_DWELL` goes to `S_NEXT` after 16 cycles.
- `S_NEXT` goes to `S_DWELL` below tap 63, or to `S_DECIDE` at tap 63.
- `S_DECIDE` goes to `S_LOCK` if a stable tap was seen, otherwise to `S_FAIL`.
- `S_LOCK` and `S_FAIL` hold until `tap_clr` or a mode change.

Top module: `dpa_tap_ctrl`

## Requirements
- R1: After reset, `tap` is 0, `locked` is 0, `no_eye` is 0 and `dbg_tap` is 0.
- R2: With `auto_mode`=1 and `full_rate`=1, `step_en`=1 in the idle state starts a sweep. The sweep sets the tap to 0 and advances it by one every 17 cycles up to 63. A tap is stable only if `obs_early`, `obs_center` and `obs_late` were all equal in each of its 16 observed cycles.
- R3: After the sweep, `tap` becomes floor((first stable + last stable)/2) and `locked` rises exactly 1089 clock edges after the edge that sampled the start. While locked, `dbg_tap` equals `tap`; otherwise `dbg_tap` is 0.
- R4: If no tap was stable, `no_eye` rises at that same edge, `locked` stays 0 and `tap` is 0.
- R5: In automatic mode with `full_rate`=0, `step_en` does not start training: `tap` keeps its value, and `locked` and `no_eye` stay 0.
- R6: In manual mode (`auto_mode`=0 for at least one earlier cycle), `step_en`=1 with `step_up`=1 raises `tap` by one at the next edge. `step_en`=1 with `step_up`=0 lowers it by one. `step_en`=0 holds it.
- R7: In manual mode `tap` saturates at 63 when stepping up and at 0 when stepping down; it never wraps.
- R8: In automatic mode `step_en` and `step_up` never move `tap` once the block is locked or failed.
- R9: `tap_clr`=1 sets `tap` to 0 at the next edge in either mode. In automatic mode it also clears `locked` and `no_eye` and returns to waiting for `step_en`.
- R10: `locked` and the locked tap stay unchanged until `tap_clr` or until `auto_mode` falls; one edge after `auto_mode` falls, `locked` is 0. `locked` and `no_eye` are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parallel (slow) clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| auto_mode | input | 1 | 1 selects automatic training, 0 selects manual stepping |
| full_rate | input | 1 | 1 when the lane is in full-rate serialization; required to start training |
| step_en | input | 1 | Starts training (automatic) or enables a step (manual) |
| step_up | input | 1 | Manual step direction: 1 up, 0 down |
| tap_clr | input | 1 | Synchronous clear of the tap, and of training in automatic mode |
| obs_early | input | 1 | Early sample from the delay line |
| obs_center | input | 1 | Centre sample from the delay line |
| obs_late | input | 1 | Late sample from the delay line |
| tap | output | 6 | Current delay tap driving the delay line |
| locked | output | 1 | Training complete; tap is centred |
| dbg_tap | output | 6 | Locked tap while locked, 0 otherwise |
| no_eye | output | 1 | Training finished without any stable tap |

## Verification
Each tap step, clear or manual step appears at the next clock edge. The bench drives inputs on the falling edge and checks `tap` on the following falling edge against a saturating count that it keeps itself. A training run takes 1 start edge plus 64 taps of 17 edges each, plus 1 decision edge. The bench therefore counts edges from the start and requires `locked` or `no_eye` on exactly the 1090th edge it counts, which is 1089 edges after the edge that sampled the start. It then compares `tap` with a midpoint computed from the eye window it programmed into its delay model, including windows with a glitching edge tap, an internal hole and no eye at all.

// File: rtl/dpa_pkg.sv
`timescale 1ns/1ps
package dpa_pkg;
    typedef enum logic [2:0] {
        S_MAN    = 3'd0,
        S_IDLE   = 3'd1,
        S_DWELL  = 3'd2,
        S_NEXT   = 3'd3,
        S_DECIDE = 3'd4,
        S_LOCK   = 3'd5,
        S_FAIL   = 3'd6
    } dpa_state_e;
endpackage

// File: rtl/dpa_tap_counter.sv
`timescale 1ns/1ps
// Saturating delay tap register: clear > load > up > down.
module dpa_tap_counter #(
    parameter int TAP_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ld,
    input  logic [TAP_W-1:0] ld_val,
    input  logic             up,
    input  logic             dn,
    output logic [TAP_W-1:0] tap
);
    localparam logic [TAP_W-1:0] TOP = {TAP_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tap <= '0;
        end else if (clr) begin
            tap <= '0;
        end else if (ld) begin
            tap <= ld_val;
        end else if (up && tap != TOP) begin
            tap <= tap + 1'b1;
        end else if (dn && tap != '0) begin
            tap <= tap - 1'b1;
        end
    end
endmodule

// File: rtl/dpa_dwell_timer.sv
`timescale 1ns/1ps
// Counts the observation cycles spent on one tap.
module dpa_dwell_timer #(
    parameter int DWELL = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CNT_W = (DWELL < 2) ? 1 : $clog2(DWELL);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DWELL - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt + 1'b1;
        end else begin
            cnt <= '0;
        end
    end

    assign done = run && (cnt == LAST);
endmodule

// File: rtl/dpa_eye_tracker.sv
`timescale 1ns/1ps
// Accumulates agreement of the three samples on a tap and records the
// lowest and highest stable taps of a sweep.
module dpa_eye_tracker #(
    parameter int TAP_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             sample,
    input  logic             judge,
    input  logic             obs_ok,
    input  logic [TAP_W-1:0] cur_tap,
    output logic             found,
    output logic [TAP_W-1:0] mid
);
    logic             ok_acc;
    logic [TAP_W-1:0] first_tap;
    logic [TAP_W-1:0] last_tap;
    logic [TAP_W:0]   span_sum;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ok_acc    <= 1'b1;
            found     <= 1'b0;
            first_tap <= '0;
            last_tap  <= '0;
        end else if (start) begin
            ok_acc    <= 1'b1;
            found     <= 1'b0;
            first_tap <= '0;
            last_tap  <= '0;
        end else if (sample) begin
            ok_acc <= ok_acc & obs_ok;
        end else if (judge) begin
            ok_acc <= 1'b1;
            if (ok_acc) begin
                if (!found) begin
                    first_tap <= cur_tap;
                end
                last_tap <= cur_tap;
                found    <= 1'b1;
            end
        end
    end

    assign span_sum = {1'b0, first_tap} + {1'b0, last_tap};
    assign mid      = span_sum[TAP_W:1];
endmodule

// File: rtl/dpa_tap_ctrl.sv
`timescale 1ns/1ps
module dpa_tap_ctrl
    import dpa_pkg::*;
#(
    parameter int TAP_W = 6,
    parameter int DWELL = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_mode,
    input  logic             full_rate,
    input  logic             step_en,
    input  logic             step_up,
    input  logic             tap_clr,
    input  logic             obs_early,
    input  logic             obs_center,
    input  logic             obs_late,
    output logic [TAP_W-1:0] tap,
    output logic             locked,
    output logic [TAP_W-1:0] dbg_tap,
    output logic             no_eye
);
    localparam logic [TAP_W-1:0] TOP = {TAP_W{1'b1}};

    dpa_state_e       state;
    dpa_state_e       nxt;
    logic             dwell_done;
    logic             eye_found;
    logic [TAP_W-1:0] eye_mid;
    logic             obs_ok;
    logic             at_top;
    logic             man_live;
    logic             go;
    logic             tc_ld;
    logic [TAP_W-1:0] tc_val;
    logic             tc_up;
    logic             tc_dn;
    logic             trk_start;
    logic             trk_sample;
    logic             trk_judge;
    logic             dwell_run;

    assign obs_ok = (obs_early == obs_center) && (obs_center == obs_late);
    assign at_top = (tap == TOP);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Next state
    always_comb begin
        nxt = state;
        if (tap_clr) begin
            nxt = auto_mode ? S_IDLE : S_MAN;
        end else if (!auto_mode) begin
            nxt = S_MAN;
        end else begin
            unique case (state)
                S_MAN:    nxt = S_IDLE;
                S_IDLE:   if (step_en && full_rate) nxt = S_DWELL;
                S_DWELL:  if (dwell_done) nxt = S_NEXT;
                S_NEXT:   nxt = at_top ? S_DECIDE : S_DWELL;
                S_DECIDE: nxt = eye_found ? S_LOCK : S_FAIL;
                S_LOCK:   nxt = S_LOCK;
                S_FAIL:   nxt = S_FAIL;
                default:  nxt = S_IDLE;
            endcase
        end
    end

    // Outputs and datapath controls
    always_comb begin
        man_live   = (state == S_MAN) && !auto_mode && !tap_clr;
        go         = auto_mode && !tap_clr;
        tc_ld      = 1'b0;
        tc_val     = '0;
        tc_up      = man_live && step_en && step_up;
        tc_dn      = man_live && step_en && !step_up;
        trk_start  = 1'b0;
        trk_sample = 1'b0;
        trk_judge  = 1'b0;
        dwell_run  = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (go && step_en && full_rate) begin
                    tc_ld     = 1'b1;
                    trk_start = 1'b1;
                end
            end
            S_DWELL: begin
                dwell_run  = go;
                trk_sample = go;
            end
            S_NEXT: begin
                trk_judge = go;
                tc_up     = go;
            end
            S_DECIDE: begin
                tc_ld  = go;
                tc_val = eye_found ? eye_mid : '0;
            end
            default: ;
        endcase
    end

    assign locked  = (state == S_LOCK);
    assign no_eye  = (state == S_FAIL);
    assign dbg_tap = locked ? tap : '0;

    dpa_tap_counter #(.TAP_W(TAP_W)) u_tap (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (tap_clr),
        .ld     (tc_ld),
        .ld_val (tc_val),
        .up     (tc_up),
        .dn     (tc_dn),
        .tap    (tap)
    );

    dpa_dwell_timer #(.DWELL(DWELL)) u_dwell (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (dwell_run),
        .done  (dwell_done)
    );

    dpa_eye_tracker #(.TAP_W(TAP_W)) u_eye (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (trk_start),
        .sample  (trk_sample),
        .judge   (trk_judge),
        .obs_ok  (obs_ok),
        .cur_tap (tap),
        .found   (eye_found),
        .mid     (eye_mid)
    );
endmodule

// File: rtl/dpa_tap_ctrl_chk.sv
`timescale 1ns/1ps
module dpa_tap_ctrl_chk
    import dpa_pkg::*;
#(
    parameter int TAP_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             auto_mode,
    input logic             full_rate,
    input logic             step_en,
    input logic             step_up,
    input logic             tap_clr,
    input logic [TAP_W-1:0] tap,
    input logic             locked,
    input logic             no_eye,
    input dpa_state_e       state
);
    localparam logic [TAP_W-1:0] TOP = {TAP_W{1'b1}};

    // R6
    a_r6_man_up: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_MAN && !auto_mode && !tap_clr && step_en && step_up && tap != TOP)
        |=> tap == $past(tap) + 1'b1);

    // R6
    a_r6_man_down: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_MAN && !auto_mode && !tap_clr && step_en && !step_up && tap != '0)
        |=> tap == $past(tap) - 1'b1);

    // R7
    a_r7_sat_top: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_MAN && !auto_mode && !tap_clr && step_en && step_up && tap == TOP)
        |=> tap == TOP);

    // R7
    a_r7_sat_bottom: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_MAN && !auto_mode && !tap_clr && step_en && !step_up && tap == '0)
        |=> tap == '0);

    // R9
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        tap_clr |=> (tap == '0 && !locked && !no_eye));

    // R4
    a_r4_fail_parks: assert property (@(posedge clk) disable iff (!rst_n)
        no_eye |-> (tap == '0 && !locked));

    // R10
    a_r10_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && auto_mode && !tap_clr) |=> (locked && $stable(tap)));

    // R5
    a_r5_half_rate_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && auto_mode && !tap_clr && !full_rate)
        |=> (state == S_IDLE && $stable(tap)));

    // R3
    a_r3_lock_after_decide: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(state) == S_DECIDE);
endmodule

bind dpa_tap_ctrl dpa_tap_ctrl_chk #(.TAP_W(TAP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .auto_mode (auto_mode),
    .full_rate (full_rate),
    .step_en   (step_en),
    .step_up   (step_up),
    .tap_clr   (tap_clr),
    .tap       (tap),
    .locked    (locked),
    .no_eye    (no_eye),
    .state     (state)
);

// File: tb/sim_dpa_tap_ctrl.sv
`timescale 1ns/1ps
module sim_dpa_tap_ctrl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       auto_mode, full_rate, step_en, step_up, tap_clr;
    logic       obs_early, obs_center, obs_late;
    logic [5:0] tap, dbg_tap;
    logic       locked, no_eye;

    always #4 clk = ~clk;

    // Behavioural delay line: window [lo,hi] is the eye, gtap flickers, hole is bad.
    int lo = -1, hi = -2, gtap = -1, hole = -1;
    logic [7:0] bc = '0;
    always @(posedge clk) bc <= bc + 1'b1;

    assign obs_center = 1'b1;
    assign obs_early  = (int'(tap) >= lo) && (int'(tap) <= hi) && !((int'(tap) == gtap) && bc[2]);
    assign obs_late   = (int'(tap) >= lo) && (int'(tap) <= hi) && (int'(tap) != hole);

    dpa_tap_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .auto_mode(auto_mode), .full_rate(full_rate),
        .step_en(step_en), .step_up(step_up), .tap_clr(tap_clr),
        .obs_early(obs_early), .obs_center(obs_center), .obs_late(obs_late),
        .tap(tap), .locked(locked), .dbg_tap(dbg_tap), .no_eye(no_eye)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            fails++;
            $display("FAIL watchdog R1..all actual=%0d expected<%0d", cyc, 150000);
            $display("  [TB] %0d tests run, %0d failed", checks + 1, fails);
            $finish;
        end
    end

    task automatic run_auto(input int l, input int h, input int g, input int ho);
        int  n;
        bit  done;
        int  first, last, m;
        bit  f;
        int  held;
        @(negedge clk);
        lo = l; hi = h; gtap = g; hole = ho;
        auto_mode = 1'b1; full_rate = 1'b1; step_en = 1'b0; tap_clr = 1'b1;
        @(negedge clk);
        tap_clr = 1'b0;
        chk(tap == 0 && !locked && !no_eye, "R9 clear before training", int'(tap), 0);
        step_en = 1'b1;
        n = 0; done = 1'b0;
        while (!done && n < 1300) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            step_en = 1'b0;
            if (n == 100) chk(!locked && dbg_tap == 0, "R3 dbg_tap zero while training", int'(dbg_tap), 0);
            if (n == 1 + 17*5) chk(tap == 5, "R2 tap advances every 17 cycles", int'(tap), 5);
            if (locked || no_eye) done = 1'b1;
        end
        first = -1; last = -1;
        for (int t = 0; t < 64; t++) begin
            if (t >= l && t <= h && t != g && t != ho) begin
                if (first < 0) first = t;
                last = t;
            end
        end
        f = (first >= 0);
        m = f ? (first + last) / 2 : 0;
        chk(n == 1090, "R3 training latency", n, 1090);
        chk(!(locked && no_eye), "R10 lock and error exclusive", int'(locked), 0);
        if (f) begin
            chk(locked, "R3 locked after sweep", int'(locked), 1);
            chk(int'(tap) == m, "R3 midpoint tap", int'(tap), m);
            chk(int'(dbg_tap) == m, "R3 dbg_tap shows lock tap", int'(dbg_tap), m);
        end else begin
            chk(no_eye, "R4 no_eye raised", int'(no_eye), 1);
            chk(tap == 0, "R4 tap parked at 0", int'(tap), 0);
            chk(!locked && dbg_tap == 0, "R4 not locked", int'(locked), 0);
        end
        held = int'(tap);
        for (int i = 0; i < 8; i++) begin
            step_en = 1'b1; step_up = (i < 4);
            @(negedge clk);
            chk(int'(tap) == held, "R8 steps ignored in auto mode", int'(tap), held);
            chk(locked == f && no_eye == !f, "R10 result held", int'(locked), int'(f));
        end
        step_en = 1'b0;
    endtask

    initial begin
        int exp_tap;
        bit en, up;
        rst_n = 1'b0; auto_mode = 1'b1; full_rate = 1'b1;
        step_en = 1'b0; step_up = 1'b0; tap_clr = 1'b0;
        repeat (3) @(negedge clk);
        chk(tap == 0 && !locked && !no_eye && dbg_tap == 0, "R1 reset state", int'(tap), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tap == 0 && !locked && !no_eye, "R1 idle after reset", int'(tap), 0);

        // R2 R3 R4: eye windows
        run_auto(10, 30, -1, -1);
        run_auto(0, 63, -1, -1);
        run_auto(63, 63, -1, -1);
        run_auto(5, 5, -1, -1);
        run_auto(40, 41, -1, -1);
        run_auto(20, 40, 20, -1);   // R2 flickering edge tap excluded
        run_auto(12, 50, -1, 30);   // R2 internal hole ignored for span
        run_auto(-1, -2, -1, -1);   // R4 no eye
        run_auto(3, 3, 3, -1);      // R4 only tap flickers

        // R5: half rate never starts training
        @(negedge clk);
        full_rate = 1'b0; tap_clr = 1'b1;
        @(negedge clk);
        tap_clr = 1'b0; step_en = 1'b1;
        repeat (40) @(negedge clk);
        chk(tap == 0 && !locked && !no_eye, "R5 no training at half rate", int'(tap), 0);
        step_en = 1'b0; full_rate = 1'b1;

        // R10: leaving auto mode drops lock
        run_auto(8, 24, -1, -1);
        @(negedge clk);
        auto_mode = 1'b0;
        @(negedge clk);
        chk(!locked && !no_eye, "R10 lock falls when auto_mode falls", int'(locked), 0);
        chk(tap == 16, "R10 tap kept on mode change", int'(tap), 16);

        // R9 manual clear
        tap_clr = 1'b1;
        @(negedge clk);
        tap_clr = 1'b0;
        chk(tap == 0, "R9 manual clear", int'(tap), 0);

        // R6 R7 manual sweep
        exp_tap = 0;
        for (int i = 0; i < 220; i++) begin
            en = ((i % 7) != 3);
            up = (i < 80) ? 1'b1 : ((i < 170) ? 1'b0 : i[0]);
            step_en = en; step_up = up;
            @(negedge clk);
            if (en && up && exp_tap < 63) exp_tap++;
            else if (en && !up && exp_tap > 0) exp_tap--;
            if (exp_tap == 63 || exp_tap == 0)
                chk(int'(tap) == exp_tap, "R7 manual saturation", int'(tap), exp_tap);
            else
                chk(int'(tap) == exp_tap, "R6 manual step", int'(tap), exp_tap);
            chk(!locked && dbg_tap == 0, "R6 no lock in manual", int'(locked), 0);
        end
        step_en = 1'b1; step_up = 1'b1;
        repeat (9) @(negedge clk);
        step_en = 1'b0;
        chk(tap != 0, "R6 tap raised before clear", int'(tap), 1);
        tap_clr = 1'b1;
        @(negedge clk);
        tap_clr = 1'b0;
        chk(tap == 0, "R9 manual clear from nonzero", int'(tap), 0);

        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule